// File: doc/BRIEF.md
# Register-Programmed SPI Host Controller

This block is an SPI master that a host processor operates through three 32-bit word registers: a control/status word, an outgoing data word and an incoming data word. One control write with the launch bit set runs one transfer of one to four bytes on one of four slave-select lines. The same write carries that transfer's SCK half-period and its select guard time. The host then polls the launch bit, which reads as one until the transfer is finished.

A per-transfer release flag decides whether the select line stays low after the transfer ends. Leaving it low lets a chain of short transfers form one long slave command, for example an opcode and address followed by many data words. The block knows nothing about the meaning of the bytes it moves. It uses SPI mode 0 and sends each byte most significant bit first.

Top module: `spi_host_regs`

## Requirements
- R1: After reset, all four `spi_cs_n` lines are high, `spi_sck` and `spi_mosi` are low, and the control, transmit and receive words all read back as zero.
- R2: Writing the control word at byte offset 0x0 with bit 31 set while idle starts a transfer. Bit 31 reads 1 from the next cycle until the transfer completes, and then reads 0.
- R3: The byte-count field (control bits 20:19) holds N-1, so a transfer produces exactly 8*(N) rising SCK edges.
- R4: A write transfer sends the transmit word (offset 0x4) MSB first, starting at bit 31, and uses only its top N bytes. MOSI is stable whenever SCK rises (mode 0).
- R5: The operation field (bits 22:21) value 1 selects a read; every other value selects a write. A read shifts MISO in on rising SCK edges and holds MOSI low. On completion the received bytes are placed in the receive word (offset 0x8) with the first byte at bits 31:24 and any unused low bytes zero. A write leaves the receive word unchanged.
- R6: SCK toggles every H system clocks, where H is control bits 18:13; H = 0 behaves as H = 1. Rising edges are therefore 2*H clocks apart.
- R7: Only the line chosen by control bits 24:23 goes low. It is low at least G + H clocks before the first rising SCK edge, where G is control bits 12:8.
- R8: If control bits 7:0 are zero, the chosen select line stays low after the transfer. If they are nonzero, the line goes high at least G clocks after the last falling SCK edge.
- R9: While bit 31 reads 1, writes to the control word and to the transmit word have no effect.
- R10: The control word reads back bit 31 as busy, bits 30:25 as zero, and bits 24:0 as last written. The transmit word reads back as last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address; bits 3:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word (combinational) |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to slave |
| spi_miso | input | 1 | Serial data from slave |
| spi_cs_n | output | 4 | Active-low slave selects |

## Verification
The bench builds the block with its default parameters: a 4-bit address, four select lines, a 6-bit half-period field and a 5-bit guard field. With these defaults every field extreme can be reached in a short run. That covers half-periods of 0, 1 and 63, guard times of 0 and 31, all four byte counts and all four select lines. A reserved operation code is also exercised, and two transfers are chained on one held select line. A slow single-byte transfer gives enough busy cycles to place ignored register writes in the middle of it.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

  localparam int WORD_W  = 32;
  localparam int BYTE_W  = 8;
  localparam int CS_W    = 2;
  localparam int NUM_CS  = 1 << CS_W;
  localparam int OP_W    = 2;
  localparam int XCNT_W  = 2;
  localparam int HALF_W  = 6;
  localparam int GUARD_W = 5;
  localparam int CSCTL_W = 8;
  localparam int BUSY_BIT = WORD_W - 1;

  localparam logic [OP_W-1:0] OP_READ = OP_W'(1);

  // Field order mirrors control word bits 24:0
  typedef struct packed {
    logic [CS_W-1:0]    cs_num;
    logic [OP_W-1:0]    op;
    logic [XCNT_W-1:0]  xcnt;
    logic [HALF_W-1:0]  half;
    logic [GUARD_W-1:0] guard;
    logic [CSCTL_W-1:0] cs_ctl;
  } xfer_cfg_t;

  localparam int CFG_W = $bits(xfer_cfg_t);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_SHIFT = 2'd2,
    ST_HOLD  = 2'd3
  } eng_state_t;

endpackage

// File: rtl/spi_host_tick.sv
module spi_host_tick #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] half,
  output logic             tick
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lim;

  assign lim  = (half == '0) ? CNT_W'(1) : half;
  assign tick = run && (cnt_q == lim - CNT_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R6
  half_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < lim));

endmodule

// File: rtl/spi_host_engine.sv
module spi_host_engine
  import spi_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  xfer_cfg_t         cfg_in,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              tick,
  input  logic              miso,
  output logic              run,
  output logic              busy,
  output logic              done,
  output logic              rd_xfer,
  output logic [WORD_W-1:0] rx_word,
  output logic              sck,
  output logic              mosi,
  output logic [NUM_CS-1:0] cs_n
);

  localparam int BIT_W = $clog2(WORD_W + 1);
  localparam int SH_W  = XCNT_W + $clog2(BYTE_W);

  eng_state_t         st_q, st_d;
  logic [GUARD_W-1:0] gap_q, gap_d;
  logic [GUARD_W-1:0] guard_q, guard_d;
  logic [BIT_W-1:0]   bits_q, bits_d;
  logic [XCNT_W-1:0]  xcnt_q, xcnt_d;
  logic [CS_W-1:0]    sel_q, sel_d;
  logic [WORD_W-1:0]  tx_sh_q, tx_sh_d;
  logic [WORD_W-1:0]  rx_sh_q, rx_sh_d;
  logic               sck_q, sck_d;
  logic               cs_on_q, cs_on_d;
  logic               rd_q, rd_d;
  logic               rel_q, rel_d;
  logic [BIT_W-1:0]   nbits;
  logic [SH_W-1:0]    align;

  assign nbits = (BIT_W'(cfg_in.xcnt) + BIT_W'(1)) << $clog2(BYTE_W);

  always_comb begin
    st_d    = st_q;
    gap_d   = gap_q;
    guard_d = guard_q;
    bits_d  = bits_q;
    xcnt_d  = xcnt_q;
    sel_d   = sel_q;
    tx_sh_d = tx_sh_q;
    rx_sh_d = rx_sh_q;
    sck_d   = sck_q;
    cs_on_d = cs_on_q;
    rd_d    = rd_q;
    rel_d   = rel_q;
    done    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d    = ST_SETUP;
          gap_d   = cfg_in.guard;
          guard_d = cfg_in.guard;
          bits_d  = nbits;
          xcnt_d  = cfg_in.xcnt;
          sel_d   = cfg_in.cs_num;
          tx_sh_d = tx_word;
          rx_sh_d = '0;
          sck_d   = 1'b0;
          cs_on_d = 1'b1;
          rd_d    = (cfg_in.op == OP_READ);
          rel_d   = (cfg_in.cs_ctl != '0);
        end
      end
      ST_SETUP: begin
        if (gap_q == '0) st_d = ST_SHIFT;
        else             gap_d = gap_q - GUARD_W'(1);
      end
      ST_SHIFT: begin
        if (tick) begin
          if (!sck_q) begin
            sck_d   = 1'b1;
            rx_sh_d = {rx_sh_q[WORD_W-2:0], miso};
            bits_d  = bits_q - BIT_W'(1);
          end else begin
            sck_d = 1'b0;
            if (bits_q == '0) begin
              st_d  = ST_HOLD;
              gap_d = guard_q;
            end else begin
              tx_sh_d = tx_sh_q << 1;
            end
          end
        end
      end
      ST_HOLD: begin
        if (!rel_q) begin
          st_d = ST_IDLE;
          done = 1'b1;
        end else if (gap_q == '0) begin
          st_d    = ST_IDLE;
          cs_on_d = 1'b0;
          done    = 1'b1;
        end else begin
          gap_d = gap_q - GUARD_W'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      gap_q   <= '0;
      guard_q <= '0;
      bits_q  <= '0;
      xcnt_q  <= '0;
      sel_q   <= '0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
      sck_q   <= 1'b0;
      cs_on_q <= 1'b0;
      rd_q    <= 1'b0;
      rel_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      gap_q   <= gap_d;
      guard_q <= guard_d;
      bits_q  <= bits_d;
      xcnt_q  <= xcnt_d;
      sel_q   <= sel_d;
      tx_sh_q <= tx_sh_d;
      rx_sh_q <= rx_sh_d;
      sck_q   <= sck_d;
      cs_on_q <= cs_on_d;
      rd_q    <= rd_d;
      rel_q   <= rel_d;
    end
  end

  // Remaining byte slots = inverse of the count field; shift those out of the bottom
  assign align   = {~xcnt_q, {$clog2(BYTE_W){1'b0}}};
  assign rx_word = rx_sh_q << align;
  assign run     = (st_q == ST_SHIFT);
  assign busy    = (st_q != ST_IDLE);
  assign rd_xfer = rd_q;
  assign sck     = sck_q;
  assign mosi    = run && !rd_q && tx_sh_q[WORD_W-1];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_n[g] = !(cs_on_q && (sel_q == CS_W'(g)));
  end

  // R7
  cs_single_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R6
  sck_only_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sck_q) |-> $past(st_q == ST_SHIFT));

  // R3
  bits_spent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HOLD) |-> (bits_q == '0 && !sck_q));

  // R7
  cs_held_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cs_n != '1));

endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
  import spi_host_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [3:0]        spi_cs_n
);

  localparam int IDX_LSB = 2;
  localparam int IDX_W   = 2;
  localparam logic [IDX_W-1:0] IDX_CTL = 2'd0;
  localparam logic [IDX_W-1:0] IDX_TX  = 2'd1;
  localparam logic [IDX_W-1:0] IDX_RX  = 2'd2;

  logic [1:0]        rst_sync_q;
  logic              rst_s_n;
  xfer_cfg_t         cfg_q, cfg_d;
  xfer_cfg_t         cfg_new;
  logic [WORD_W-1:0] tx_q, tx_d;
  logic [WORD_W-1:0] rx_q, rx_d;
  logic [IDX_W-1:0]  idx;
  logic              wr_ctl, wr_tx, start;
  logic              busy, done, rd_xfer, tick, run;
  logic [WORD_W-1:0] rx_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  assign idx     = bus_addr[IDX_LSB +: IDX_W];
  assign cfg_new = xfer_cfg_t'(bus_wdata[CFG_W-1:0]);
  assign wr_ctl  = bus_we && (idx == IDX_CTL) && !busy;
  assign wr_tx   = bus_we && (idx == IDX_TX) && !busy;
  assign start   = wr_ctl && bus_wdata[BUSY_BIT];

  always_comb begin
    cfg_d = cfg_q;
    tx_d  = tx_q;
    rx_d  = rx_q;
    if (wr_ctl)            cfg_d = cfg_new;
    if (wr_tx)             tx_d  = bus_wdata;
    if (done && rd_xfer)   rx_d  = rx_word;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      cfg_q <= '0;
      tx_q  <= '0;
      rx_q  <= '0;
    end else begin
      cfg_q <= cfg_d;
      tx_q  <= tx_d;
      rx_q  <= rx_d;
    end
  end

  always_comb begin
    unique case (idx)
      IDX_CTL: bus_rdata = {busy, {(WORD_W-1-CFG_W){1'b0}}, cfg_q};
      IDX_TX:  bus_rdata = tx_q;
      IDX_RX:  bus_rdata = rx_q;
      default: bus_rdata = '0;
    endcase
  end

  spi_host_tick #(.CNT_W(HALF_W)) u_tick (
    .clk   (clk),
    .rst_n (rst_s_n),
    .run   (run),
    .half  (cfg_q.half),
    .tick  (tick)
  );

  spi_host_engine u_eng (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .start   (start),
    .cfg_in  (cfg_new),
    .tx_word (tx_q),
    .tick    (tick),
    .miso    (spi_miso),
    .run     (run),
    .busy    (busy),
    .done    (done),
    .rd_xfer (rd_xfer),
    .rx_word (rx_word),
    .sck     (spi_sck),
    .mosi    (spi_mosi),
    .cs_n    (spi_cs_n)
  );

  // R9
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (busy && $past(busy)) |-> $stable(cfg_q));

  // R9
  tx_frozen_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (busy && $past(busy)) |-> $stable(tx_q));

  // R5
  rx_on_read_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !$stable(rx_q) |-> $past(done && rd_xfer));

endmodule

// File: tb/spi_host_regs_tb_top.sv
module spi_host_regs_tb_top;

  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  xcnt;
    logic [5:0]  half;
    logic [4:0]  guard;
    logic [1:0]  cs;
    logic [7:0]  csctl;
    logic [31:0] tx;
    logic [31:0] slv;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd0, 6'd2,  5'd2,  2'd0, 8'h40, 32'hA500_0000, 32'h0000_0000},
    '{2'd0, 2'd3, 6'd1,  5'd0,  2'd1, 8'h01, 32'h1234_5678, 32'hFFFF_FFFF},
    '{2'd1, 2'd0, 6'd3,  5'd1,  2'd2, 8'h40, 32'h7777_7777, 32'hC355_AA11},
    '{2'd1, 2'd3, 6'd0,  5'd3,  2'd3, 8'h01, 32'h0000_0000, 32'hDEAD_BEEF},
    '{2'd0, 2'd1, 6'd4,  5'd4,  2'd0, 8'h00, 32'h9F3C_0000, 32'h0000_0000},
    '{2'd1, 2'd1, 6'd2,  5'd2,  2'd0, 8'h80, 32'h0000_0000, 32'h8142_FFFF},
    '{2'd2, 2'd2, 6'd1,  5'd1,  2'd1, 8'h01, 32'h0F1E_2D00, 32'h0000_0000},
    '{2'd0, 2'd0, 6'd63, 5'd31, 2'd3, 8'h01, 32'h8000_0000, 32'h0000_0000}
  };

  logic        clk;
  logic        rst_n;
  logic        bus_we;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        spi_sck, spi_mosi, spi_miso;
  logic [3:0]  spi_cs_n;

  int n_chk, n_err;
  int clr_req, clr_seen;
  int rise_cnt, since_start, since_rise, since_fall, first_lead, gap, hold_cyc;
  logic [31:0] mosi_cap;
  logic [3:0]  cs_at_rise;
  logic        sck_prev, cs_prev_all;
  logic [31:0] slv_word;
  int          slv_idx;
  logic [31:0] rx_exp;
  bit          finished;

  spi_host_regs dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .spi_sck   (spi_sck),
    .spi_mosi  (spi_mosi),
    .spi_miso  (spi_miso),
    .spi_cs_n  (spi_cs_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  assign spi_miso = (slv_idx < 32) ? slv_word[31 - slv_idx] : 1'b0;

  // Line monitor and slave model, sampled on the falling system clock
  always @(negedge clk) begin
    if (clr_req != clr_seen) begin
      clr_seen   = clr_req;
      rise_cnt   = 0;
      mosi_cap   = '0;
      since_start = 0;
      first_lead = -1;
      gap        = 0;
      hold_cyc   = -1;
      cs_at_rise = 4'hF;
      slv_idx    = 0;
    end
    since_start++;
    since_rise++;
    since_fall++;
    if (spi_sck && !sck_prev) begin
      if (rise_cnt == 0) begin
        first_lead = since_start;
        cs_at_rise = spi_cs_n;
      end else begin
        gap = since_rise;
      end
      since_rise = 0;
      rise_cnt++;
      mosi_cap = {mosi_cap[30:0], spi_mosi};
    end
    if (!spi_sck && sck_prev) begin
      since_fall = 0;
      slv_idx++;
    end
    if ((&spi_cs_n) && !cs_prev_all) hold_cyc = since_fall;
    sck_prev    = spi_sck;
    cs_prev_all = &spi_cs_n;
  end

  task automatic step();
    @(negedge clk);
    #2;
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    step();
    bus_we    = 1'b1;
    bus_addr  = a;
    bus_wdata = d;
    step();
    bus_we    = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] r;
    int n;
    n = 0;
    bus_read(4'h0, r);
    while (r[31] && n < 20000) begin
      step();
      bus_read(4'h0, r);
      n++;
    end
    check(!r[31], req, r, 32'h0);
  endtask

  task automatic launch(input vec_t v);
    slv_word = v.slv;
    bus_write(4'h4, v.tx);
    bus_write(4'h0, {1'b1, 6'b0, v.cs, v.op, v.xcnt, v.half, v.guard, v.csctl});
    clr_req++;
  endtask

  task automatic run_vec(input vec_t v);
    logic [31:0] r, exp_m, mask, ones;
    int nb, h;
    launch(v);
    bus_read(4'h0, r);
    check(r[31] == 1'b1, "R2 busy after launch", r, 32'h8000_0000);
    wait_idle("R2 busy clears");
    nb   = 8 * (int'(v.xcnt) + 1);
    h    = (v.half == 0) ? 1 : int'(v.half);
    ones = '1;
    check(rise_cnt == nb, "R3 rising edges", rise_cnt, nb);
    check(gap == 2 * h, "R6 edge spacing", gap, 2 * h);
    check(first_lead >= int'(v.guard) + h, "R7 select lead", first_lead, int'(v.guard) + h);
    check(cs_at_rise == ~(4'b1 << v.cs), "R7 select line", cs_at_rise, ~(4'b1 << v.cs));
    mask = (nb == 32) ? ones : ((32'd1 << nb) - 32'd1);
    if (v.op == 2'd1) begin
      rx_exp = v.slv & ~(ones >> nb);
      check(mosi_cap == 32'h0, "R5 mosi low on read", mosi_cap, 32'h0);
    end else begin
      exp_m = v.tx >> (32 - nb);
      check((mosi_cap & mask) == exp_m, "R4 mosi bits", mosi_cap & mask, exp_m);
    end
    bus_read(4'h8, r);
    check(r == rx_exp, "R5 receive word", r, rx_exp);
    if (v.csctl == 8'h00) begin
      check(spi_cs_n == ~(4'b1 << v.cs), "R8 select kept", spi_cs_n, ~(4'b1 << v.cs));
    end else begin
      check(spi_cs_n == 4'hF, "R8 select released", spi_cs_n, 32'hF);
      check(hold_cyc >= int'(v.guard), "R8 release guard", hold_cyc, v.guard);
    end
    bus_read(4'h0, r);
    check(r == {7'b0, v.cs, v.op, v.xcnt, v.half, v.guard, v.csctl}, "R10 control readback",
          r, {7'b0, v.cs, v.op, v.xcnt, v.half, v.guard, v.csctl});
  endtask

  initial begin
    finished = 0;
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    vec_t v;
    n_chk = 0; n_err = 0; clr_req = 0; clr_seen = 0;
    rise_cnt = 0; since_start = 0; since_rise = 0; since_fall = 0;
    first_lead = -1; gap = 0; hold_cyc = -1; mosi_cap = '0; cs_at_rise = 4'hF;
    sck_prev = 1'b0; cs_prev_all = 1'b1; slv_word = '0; slv_idx = 0; rx_exp = '0;
    bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; rst_n = 1'b0;
    repeat (4) step();
    rst_n = 1'b1;
    repeat (4) step();

    // R1 reset state
    check(spi_cs_n == 4'hF, "R1 selects high", spi_cs_n, 32'hF);
    check(!spi_sck && !spi_mosi, "R1 sck/mosi low", {spi_sck, spi_mosi}, 32'h0);
    bus_read(4'h0, r); check(r == 32'h0, "R1 control zero", r, 32'h0);
    bus_read(4'h4, r); check(r == 32'h0, "R1 transmit zero", r, 32'h0);
    bus_read(4'h8, r); check(r == 32'h0, "R1 receive zero", r, 32'h0);

    // R2 R3 R4 R5 R6 R7 R8 R10 table walk
    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R10 control write without launch only updates fields
    bus_write(4'h0, {1'b0, 6'b0, 2'd2, 2'd1, 2'd2, 6'd5, 5'd7, 8'h33});
    bus_read(4'h0, r);
    check(r == {7'b0, 2'd2, 2'd1, 2'd2, 6'd5, 5'd7, 8'h33}, "R10 idle control write", r,
          {7'b0, 2'd2, 2'd1, 2'd2, 6'd5, 5'd7, 8'h33});
    check(spi_cs_n == 4'hF && !spi_sck, "R2 no launch without bit 31", spi_cs_n, 32'hF);

    // R9 writes during a busy transfer are dropped
    v = '{2'd0, 2'd0, 6'd20, 5'd3, 2'd2, 8'h01, 32'h5A00_0000, 32'h0};
    launch(v);
    bus_write(4'h4, 32'hFFFF_FFFF);
    bus_write(4'h0, {1'b1, 6'b0, 2'd1, 2'd1, 2'd3, 6'd1, 5'd0, 8'h00});
    bus_read(4'h4, r);
    check(r == 32'h5A00_0000, "R9 transmit write ignored", r, 32'h5A00_0000);
    wait_idle("R9 busy clears");
    check(mosi_cap[7:0] == 8'h5A, "R9 sent byte", mosi_cap, 32'h5A);
    check(cs_at_rise == 4'b1011, "R9 select unchanged", cs_at_rise, 32'hB);
    bus_read(4'h0, r);
    check(r == {7'b0, 2'd2, 2'd0, 2'd0, 6'd20, 5'd3, 8'h01}, "R9 control write ignored", r,
          {7'b0, 2'd2, 2'd0, 2'd0, 6'd20, 5'd3, 8'h01});
    step();
    check(spi_cs_n == 4'hF && !spi_sck, "R9 no second launch", spi_cs_n, 32'hF);

    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule